// File: doc/BRIEF.md
# Locality Command and Completion Status Engine

This block turns a short stream of locality-control commands into a sticky, read-only status word. A command arrives as a single-cycle strobe carrying a 4-bit opcode. The engine tracks whether locality 1, locality 2 and a private mode are currently open. A status bit never moves when its command is seen. The engine holds the decoded command until the downstream address decoder acknowledges that it now decodes cycles under the new state, and only then updates the bit.

Two further status bits are live completion flags. They are computed in the same cycle from an 8-bit join vector and an 8-bit exists vector. One flag reports that no participant has joined. The other reports that the joined set matches the existing set exactly.

Only one command can wait for acknowledge at a time. A strobe that arrives while a command is waiting raises a busy output for that cycle and is discarded. Opcodes outside the six defined ones are ignored.

Top module: `lcs_engine`

## Requirements
- R1: While reset is asserted, and after its release with no command applied, status bits 15, 16 and 7 read 0 and `cmd_busy` reads 0.
- R2: Opcode 4'h1 opens locality 1, which sets status bit 15. Opcode 4'h2 closes it, which clears bit 15.
- R3: Opcode 4'h3 opens locality 2, which sets status bit 16. Opcode 4'h4 closes it, which clears bit 16.
- R4: Opcode 4'h5 (open private) sets bit 16. It also sets bit 7, but only if `err_low` was 0 in the cycle the command was accepted. Opcode 4'h6 (close private) clears both bit 16 and bit 7. A close of locality 2 leaves bit 7 unchanged.
- R5: An accepted command changes no status bit until `dec_ack` is sampled high on a rising edge. The bit changes in the cycle that follows that edge, and the command is then retired.
- R6: If `cmd_valid` is high while a command is waiting, `cmd_busy` is high in that same cycle and the new command has no effect. This holds even in the cycle the acknowledge arrives.
- R7: Opcodes 4'h0 and 4'h7 to 4'hF are ignored. They change no status bit, raise no busy, and leave nothing for a later `dec_ack` to apply.
- R8: Status bit 1 equals 1 exactly when `join_vec` is all zero, in the same cycle.
- R9: Status bit 0 equals 1 exactly when `join_vec` equals `exists_vec`, in the same cycle.
- R10: Status bits 63:17, 14:8 and 6:2 always read 0.
- R11: `dec_ack` with no command waiting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| err_low | input | 1 | Bit 0 of the error-status word; gates the private-open bit |
| join_vec | input | 8 | Join tracking vector |
| exists_vec | input | 8 | Exists vector |
| dec_ack | input | 1 | Address decoder has switched to the pending state |
| cmd_busy | output | 1 | Strobe rejected because a command is still waiting |
| status | output | 64 | Read-only status word |

## Verification
The hardest situation to reach from the ports is a second strobe landing in the exact cycle that the acknowledge retires the first command. A second hard case is an `err_low` change between acceptance of an open-private command and its acknowledge. The stimulus reaches both by holding the acknowledge back for several cycles and then driving strobe, opcode, acknowledge and error bit together in chosen cycles. A behavioural model updated on every edge shows whether the late strobe leaked in and whether the error bit was sampled at acceptance rather than at acknowledge.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
   localparam int unsigned OP_W = 4;

   localparam logic [OP_W-1:0] OPC_OPEN_L1   = 4'h1;
   localparam logic [OP_W-1:0] OPC_CLOSE_L1  = 4'h2;
   localparam logic [OP_W-1:0] OPC_OPEN_L2   = 4'h3;
   localparam logic [OP_W-1:0] OPC_CLOSE_L2  = 4'h4;
   localparam logic [OP_W-1:0] OPC_OPEN_PRV  = 4'h5;
   localparam logic [OP_W-1:0] OPC_CLOSE_PRV = 4'h6;

   // status word bit positions (software decodes these)
   localparam int unsigned POS_ENTER = 0;
   localparam int unsigned POS_EXIT  = 1;
   localparam int unsigned POS_PRV   = 7;
   localparam int unsigned POS_L1    = 15;
   localparam int unsigned POS_L2    = 16;

   // tracked sticky bits, index into the action vectors
   localparam int unsigned IDX_L1  = 0;
   localparam int unsigned IDX_L2  = 1;
   localparam int unsigned IDX_PRV = 2;
   localparam int unsigned NSTATE  = 3;

   typedef struct packed {
      logic [NSTATE-1:0] set_v;
      logic [NSTATE-1:0] clr_v;
   } lcs_act_t;
endpackage

// File: rtl/lcs_cmd_decode.sv
module lcs_cmd_decode
   import lcs_pkg::*;
(
   input  logic [OP_W-1:0] cmd_op,
   input  logic            err_low,
   output lcs_act_t        act,
   output logic            known
);
   always_comb begin
      act   = '0;
      known = 1'b1;
      unique case (cmd_op)
         OPC_OPEN_L1:   act.set_v[IDX_L1] = 1'b1;
         OPC_CLOSE_L1:  act.clr_v[IDX_L1] = 1'b1;
         OPC_OPEN_L2:   act.set_v[IDX_L2] = 1'b1;
         OPC_CLOSE_L2:  act.clr_v[IDX_L2] = 1'b1;
         OPC_OPEN_PRV: begin
            act.set_v[IDX_L2]  = 1'b1;
            act.set_v[IDX_PRV] = ~err_low;
         end
         OPC_CLOSE_PRV: begin
            act.clr_v[IDX_L2]  = 1'b1;
            act.clr_v[IDX_PRV] = 1'b1;
         end
         default: known = 1'b0;
      endcase
   end
endmodule

// File: rtl/lcs_pending.sv
module lcs_pending
   import lcs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cmd_valid,
   input  logic     known,
   input  lcs_act_t act_in,
   input  logic     dec_ack,
   output logic     pend,
   output logic     apply,
   output lcs_act_t act_out,
   output logic     cmd_busy
);
   logic     pend_q;
   lcs_act_t act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         act_q  <= '0;
      end else if (pend_q) begin
         if (dec_ack) pend_q <= 1'b0;
      end else if (cmd_valid && known) begin
         pend_q <= 1'b1;
         act_q  <= act_in;
      end
   end

   assign pend     = pend_q;
   assign apply    = pend_q & dec_ack;
   assign act_out  = act_q;
   assign cmd_busy = cmd_valid & pend_q;

   AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && dec_ack) |=> !pend_q); // R5
   AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && pend_q && !dec_ack) |=> (pend_q && $stable(act_q))); // R6
endmodule

// File: rtl/lcs_state_regs.sv
module lcs_state_regs
   import lcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply,
   input  lcs_act_t          act,
   output logic [NSTATE-1:0] state
);
   logic [NSTATE-1:0] st_q;

   for (genvar g = 0; g < NSTATE; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                     st_q[g] <= 1'b0;
         else if (apply && act.clr_v[g]) st_q[g] <= 1'b0;
         else if (apply && act.set_v[g]) st_q[g] <= 1'b1;
      end
   end

   assign state = st_q;

   AST_HOLD_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable(st_q)); // R5
endmodule

// File: rtl/lcs_join_cmp.sv
module lcs_join_cmp #(
   parameter int unsigned JOIN_W   = 8,
   parameter bit          XOR_TREE = 1'b0
) (
   input  logic [JOIN_W-1:0] join_vec,
   input  logic [JOIN_W-1:0] exists_vec,
   output logic              exit_done,
   output logic              enter_done
);
   if (JOIN_W < 1) begin : g_bad_w
      $error("lcs_join_cmp: JOIN_W must be at least 1");
   end

   if (XOR_TREE) begin : g_xor
      logic [JOIN_W-1:0] diff;
      for (genvar i = 0; i < JOIN_W; i++) begin : g_d
         assign diff[i] = join_vec[i] ^ exists_vec[i];
      end
      assign enter_done = ~|diff;
      assign exit_done  = ~|join_vec;
   end else begin : g_eq
      assign enter_done = (join_vec == exists_vec);
      assign exit_done  = (join_vec == '0);
   end
endmodule

// File: rtl/lcs_engine.sv
module lcs_engine
   import lcs_pkg::*;
#(
   parameter int unsigned STS_W        = 64,
   parameter int unsigned JOIN_W       = 8,
   parameter bit          CMP_XOR_TREE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic              err_low,
   input  logic [JOIN_W-1:0] join_vec,
   input  logic [JOIN_W-1:0] exists_vec,
   input  logic              dec_ack,
   output logic              cmd_busy,
   output logic [STS_W-1:0]  status
);
   if (STS_W <= POS_L2) begin : g_bad_sts
      $error("lcs_engine: STS_W too narrow for the status layout");
   end

   lcs_act_t          dec_act, pend_act;
   logic              known, pend, apply;
   logic [NSTATE-1:0] state;
   logic              exit_done, enter_done;

   lcs_cmd_decode u_dec (
      .cmd_op (cmd_op),
      .err_low(err_low),
      .act    (dec_act),
      .known  (known)
   );

   lcs_pending u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .known    (known),
      .act_in   (dec_act),
      .dec_ack  (dec_ack),
      .pend     (pend),
      .apply    (apply),
      .act_out  (pend_act),
      .cmd_busy (cmd_busy)
   );

   lcs_state_regs u_st (
      .clk  (clk),
      .rst_n(rst_n),
      .apply(apply),
      .act  (pend_act),
      .state(state)
   );

   lcs_join_cmp #(.JOIN_W(JOIN_W), .XOR_TREE(CMP_XOR_TREE)) u_cmp (
      .join_vec  (join_vec),
      .exists_vec(exists_vec),
      .exit_done (exit_done),
      .enter_done(enter_done)
   );

   always_comb begin
      status            = '0;
      status[POS_ENTER] = enter_done;
      status[POS_EXIT]  = exit_done;
      status[POS_PRV]   = state[IDX_PRV];
      status[POS_L1]    = state[IDX_L1];
      status[POS_L2]    = state[IDX_L2];
   end

   AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !known && !pend) |=> !pend); // R7
   AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_ack && !pend) |=> $stable(state)); // R11
   AST_LIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (join_vec == '0 && exists_vec == '0) |-> (enter_done && exit_done)); // R8
   AST_LIVE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (join_vec != exists_vec) |-> !enter_done); // R9
endmodule

// File: tb/lcs_engine_bench.sv
module lcs_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = 4'h0;
   logic        err_low = 1'b0;
   logic [7:0]  join_vec = 8'h00;
   logic [7:0]  exists_vec = 8'h00;
   logic        dec_ack = 1'b0;
   logic        cmd_busy;
   logic [63:0] status;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // behavioural reference
   bit m_l1, m_l2, m_prv, m_pend, m_prv_ok;
   int m_op;

   always #5 clk = ~clk;

   lcs_engine u_lcs_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .err_low(err_low), .join_vec(join_vec), .exists_vec(exists_vec),
      .dec_ack(dec_ack), .cmd_busy(cmd_busy), .status(status)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_l1 = 0; m_l2 = 0; m_prv = 0; m_pend = 0; m_prv_ok = 0; m_op = 0;
      end else if (m_pend) begin
         if (dec_ack) begin
            m_pend = 0;
            case (m_op)
               1: m_l1 = 1;
               2: m_l1 = 0;
               3: m_l2 = 1;
               4: m_l2 = 0;
               5: begin m_l2 = 1; if (m_prv_ok) m_prv = 1; end
               6: begin m_l2 = 0; m_prv = 0; end
               default: ;
            endcase
         end
      end else if (cmd_valid && cmd_op >= 4'h1 && cmd_op <= 4'h6) begin
         m_pend = 1;
         m_op = int'(cmd_op);
         m_prv_ok = !err_low;
      end
   end

   task automatic chk(input string req, input string stp, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (step %s) actual=%h expected=%h", req, stp, act, exp);
      end
   endtask

   task automatic compare(input string stp);
      logic [63:0] resv;
      resv = status;
      resv[0] = 0; resv[1] = 0; resv[7] = 0; resv[15] = 0; resv[16] = 0;
      chk("R2", stp, 64'(status[15]), 64'(m_l1));
      chk("R3", stp, 64'(status[16]), 64'(m_l2));
      chk("R4", stp, 64'(status[7]),  64'(m_prv));
      chk("R8", stp, 64'(status[1]),  64'(join_vec == 8'h00));
      chk("R9", stp, 64'(status[0]),  64'(join_vec == exists_vec));
      chk("R10", stp, resv, 64'h0);
      chk("R6", stp, 64'(cmd_busy), 64'(cmd_valid && m_pend));
   endtask

   task automatic step(input logic v, input logic [3:0] op, input logic ack,
                       input logic err, input string stp);
      @(negedge clk);
      cmd_valid = v; cmd_op = op; dec_ack = ack; err_low = err;
      #1;
      compare(stp);
   endtask

   task automatic idle(input int n, input string stp);
      for (int i = 0; i < n; i++) step(0, 4'h0, 0, 0, stp);
   endtask

   // issue, wait without ack (deferral visible), then acknowledge
   task automatic cmd(input logic [3:0] op, input logic err, input string stp);
      step(1, op, 0, err, stp);
      idle(3, "R5");
      step(0, 4'h0, 1, 0, stp);
      idle(1, stp);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1 reset
      idle(3, "R1");
      @(negedge clk); rst_n = 1'b1;
      idle(2, "R1");
      chk("R1", "R1", status, 64'h3);

      // R8 / R9 live flags
      join_vec = 8'h05; exists_vec = 8'h05; idle(1, "R9");
      join_vec = 8'h00; exists_vec = 8'h10; idle(1, "R8");
      join_vec = 8'h0F; exists_vec = 8'hF0; idle(1, "R9");
      join_vec = 8'h80; exists_vec = 8'h80; idle(1, "R9");
      join_vec = 8'h00; exists_vec = 8'h00;

      // R2 / R3
      cmd(4'h1, 0, "R2");
      chk("R2", "open-l1", 64'(status[15]), 64'd1);
      cmd(4'h3, 0, "R3");
      cmd(4'h2, 0, "R2");
      chk("R2", "close-l1", 64'(status[15]), 64'd0);
      cmd(4'h4, 0, "R3");

      // R4 private with and without error
      cmd(4'h5, 0, "R4");
      chk("R4", "open-prv", 64'(status[7]), 64'd1);
      cmd(4'h4, 0, "R4");
      chk("R4", "close-l2 keeps prv", 64'(status[7]), 64'd1);
      cmd(4'h6, 0, "R4");
      cmd(4'h5, 1, "R4");
      chk("R4", "open-prv err", 64'(status[7]), 64'd0);
      cmd(4'h6, 0, "R4");
      // error changes after acceptance
      step(1, 4'h5, 0, 0, "R4");
      step(0, 4'h0, 0, 1, "R4");
      step(0, 4'h0, 1, 1, "R4");
      idle(1, "R4");
      chk("R4", "err sampled at accept", 64'(status[7]), 64'd1);
      cmd(4'h6, 0, "R4");

      // R6 busy drops second command, including on the ack cycle
      step(1, 4'h1, 0, 0, "R6");
      step(1, 4'h3, 0, 0, "R6");
      step(1, 4'h5, 1, 0, "R6");
      idle(2, "R6");
      chk("R6", "dropped", 64'(status[16]), 64'd0);
      cmd(4'h2, 0, "R6");

      // R7 unknown opcodes
      step(1, 4'h0, 0, 0, "R7");
      for (int op = 7; op < 16; op++) step(1, 4'(op), 0, 0, "R7");
      step(0, 4'h0, 1, 0, "R7");
      idle(2, "R7");
      chk("R7", "unknown", status, 64'h3);

      // R11 stray acknowledges
      step(0, 4'h0, 1, 0, "R11");
      step(0, 4'h0, 1, 0, "R11");
      idle(1, "R11");
      cmd(4'h3, 0, "R11");
      step(0, 4'h0, 1, 0, "R11");
      idle(1, "R11");

      // reset clears sticky bits
      @(negedge clk); rst_n = 1'b0;
      idle(2, "R1");
      @(negedge clk); rst_n = 1'b1;
      idle(1, "R1");
      chk("R1", "re-reset", status, 64'h3);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule